// File: doc/BRIEF.md
# Variable-Length Instruction Byte Decoder

This block takes an instruction byte stream, one byte per clock, and turns it into decoded instruction records. It handles a small subset of a byte-oriented, variable-length instruction encoding: a one-byte register push and pop, a one-byte return, a relative call with a multi-byte displacement, and a register-source move. The move takes a packed mode/register byte and may have a leading width prefix. Each complete instruction gives exactly one record. The record carries the operation, the register numbers, a 64-bit operand flag, the sign-extended displacement and the number of bytes the instruction used. An encoding outside the subset gives an illegal record, and decoding starts again with the next byte.

Both edges of the block are valid/ready streams. An input byte is taken on a clock where `in_valid` and `in_ready` are both high. A record is handed over on a clock where `out_valid` and `out_ready` are both high. The block holds one finished record. Input ready is high whenever that holding slot is empty or is being emptied in the same cycle, so back-pressure on the output stops the input straight away. No byte is dropped and none is decoded twice. A record that is not accepted stays unchanged until it is accepted.

Top module: `insn_byte_decoder`

## Requirements
- R1: A first byte of 0x50 to 0x57 gives a record with operation code 0 (push), `out_src` equal to the low three bits of the byte, `out_dst` 0 and length 1.
- R2: A first byte of 0x58 to 0x5F gives operation code 1 (pop), `out_dst` equal to the byte minus 0x58, `out_src` 0 and length 1.
- R3: Byte 0x89 is followed by a mode/register byte. Its bits 7:6 are the mode, bits 5:3 the source register and bits 2:0 the destination or base register. Mode 11 gives operation code 2 (register move). Mode 00 gives operation code 3 (store through base register, base in `out_dst`). Without a prefix the length is 2.
- R4: A leading 0x48 sets `out_wide` on the record that follows and adds one to its length (3 for a prefixed move).
- R5: Byte 0xE8 is a call followed by DISP_BYTES displacement bytes (4 by default). The first byte received is the least significant. The result is sign-extended to 64 bits and given operation code 4 with length DISP_BYTES+1. Every other operation reports a displacement of 0.
- R6: Byte 0xC3 gives operation code 5 (return) with length 1.
- R7: Operation code 7 (illegal) is given for modes 01 and 10, for a prefix followed by anything but 0x89, and for any other first byte. Its length counts the bytes consumed including the offending one. Its registers and displacement are 0, and `out_wide` shows whether a prefix was seen. The next byte starts a new instruction.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every record output stays unchanged on the next clock.
- R9: During and after reset `out_valid` is 0, `in_ready` is 1 and the decoder expects the first byte of an instruction.
- R10: Records come out in stream order, one for each instruction. Every accepted byte belongs to exactly one record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | A decoded record is held |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_op | output | 3 | Operation code (0 push, 1 pop, 2 move, 3 store, 4 call, 5 return, 7 illegal) |
| out_src | output | 3 | Source register number |
| out_dst | output | 3 | Destination or base register number |
| out_wide | output | 1 | 64-bit operand prefix was present |
| out_disp | output | 64 | Sign-extended call displacement |
| out_len | output | 4 | Instruction length in bytes |

## Verification
The hardest case to reach from the ports is the final byte of an instruction being offered while the previous record is still held and not accepted. In that case the byte has to wait and must not be taken. This matters most when that byte is the last displacement byte of a call or the mode byte after a prefix. The stimulus makes this happen with periodic long windows of `out_ready` low, placed over a mixed stream that keeps offering bytes. Random gaps on both sides are added between those windows. A behavioural model is fed only with bytes it sees accepted, and it checks each handed-over record against its own queue of expected records.

// File: rtl/ibd_pkg.sv
`timescale 1ns/1ps
package ibd_pkg;

  localparam int REC_LEN_W  = 4;
  localparam int REC_DISP_W = 64;

  localparam logic [7:0] BYTE_WIDE_PFX = 8'h48;
  localparam logic [7:0] BYTE_MOV_REG  = 8'h89;
  localparam logic [7:0] BYTE_CALL_REL = 8'hE8;
  localparam logic [7:0] BYTE_RETURN   = 8'hC3;

  typedef enum logic [2:0] {
    OP_PUSH    = 3'd0,
    OP_POP     = 3'd1,
    OP_MOV_RR  = 3'd2,
    OP_MOV_ST  = 3'd3,
    OP_CALL    = 3'd4,
    OP_RET     = 3'd5,
    OP_ILLEGAL = 3'd7
  } op_e;

  typedef struct packed {
    op_e                   op;
    logic [2:0]            src;
    logic [2:0]            dst;
    logic                  wide;
    logic [REC_DISP_W-1:0] disp;
    logic [REC_LEN_W-1:0]  len;
  } rec_t;

endpackage

// File: rtl/ibd_opcode_class.sv
`timescale 1ns/1ps
// Classifies a leading instruction byte.
module ibd_opcode_class
  import ibd_pkg::*;
(
  input  logic [7:0] op_byte,
  output logic       is_push,
  output logic       is_pop,
  output logic       is_ret,
  output logic       is_call,
  output logic       is_mov,
  output logic       is_pfx,
  output logic [2:0] reg_num
);

  always_comb begin
    is_push = (op_byte[7:3] == 5'b01010);
    is_pop  = (op_byte[7:3] == 5'b01011);
    is_ret  = (op_byte == BYTE_RETURN);
    is_call = (op_byte == BYTE_CALL_REL);
    is_mov  = (op_byte == BYTE_MOV_REG);
    is_pfx  = (op_byte == BYTE_WIDE_PFX);
    reg_num = op_byte[2:0];
  end

endmodule

// File: rtl/ibd_assembler.sv
`timescale 1ns/1ps
// Walks through the bytes of one instruction and forms its record.
module ibd_assembler
  import ibd_pkg::*;
#(
  parameter int DISP_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic [7:0] in_byte,
  output logic       done,
  output rec_t       rec
);

  localparam int DW    = DISP_BYTES * 8;
  localparam int CNT_W = $clog2(DISP_BYTES + 1);

  typedef enum logic [1:0] {ST_FIRST, ST_PFX, ST_MODRM, ST_DISP} st_e;

  st_e                  state_q, state_d;
  logic                 wide_q;
  logic [REC_LEN_W-1:0] len_q, len_now;
  logic [CNT_W-1:0]     cnt_q;
  logic [DW-1:0]        disp_q, disp_shift;
  logic [REC_DISP_W-1:0] disp_ext;

  logic c_push, c_pop, c_ret, c_call, c_mov, c_pfx;
  logic [2:0] c_reg;

  ibd_opcode_class i_class (
    .op_byte (in_byte),
    .is_push (c_push),
    .is_pop  (c_pop),
    .is_ret  (c_ret),
    .is_call (c_call),
    .is_mov  (c_mov),
    .is_pfx  (c_pfx),
    .reg_num (c_reg)
  );

  // Little-endian shift: newest byte enters at the top.
  generate
    if (DISP_BYTES == 1) begin : g_shift_one
      assign disp_shift = in_byte;
    end else begin : g_shift_many
      assign disp_shift = {in_byte, disp_q[DW-1:8]};
    end
    if (DW >= REC_DISP_W) begin : g_ext_none
      assign disp_ext = disp_shift[REC_DISP_W-1:0];
    end else begin : g_ext_sign
      assign disp_ext = {{(REC_DISP_W-DW){disp_shift[DW-1]}}, disp_shift};
    end
  endgenerate

  assign len_now = len_q + REC_LEN_W'(1);

  always_comb begin
    state_d  = state_q;
    done     = 1'b0;
    rec      = '0;
    rec.op   = OP_ILLEGAL;
    rec.wide = wide_q;
    rec.len  = len_now;
    unique case (state_q)
      ST_FIRST: begin
        if (c_pfx)       state_d = ST_PFX;
        else if (c_mov)  state_d = ST_MODRM;
        else if (c_call) state_d = ST_DISP;
        else begin
          done = 1'b1;
          if (c_push) begin
            rec.op  = OP_PUSH;
            rec.src = c_reg;
          end else if (c_pop) begin
            rec.op  = OP_POP;
            rec.dst = c_reg;
          end else if (c_ret) begin
            rec.op  = OP_RET;
          end
        end
      end
      ST_PFX: begin
        if (c_mov) state_d = ST_MODRM;
        else       done    = 1'b1;
      end
      ST_MODRM: begin
        done = 1'b1;
        if (in_byte[7:6] == 2'b11) begin
          rec.op  = OP_MOV_RR;
          rec.src = in_byte[5:3];
          rec.dst = in_byte[2:0];
        end else if (in_byte[7:6] == 2'b00) begin
          rec.op  = OP_MOV_ST;
          rec.src = in_byte[5:3];
          rec.dst = in_byte[2:0];
        end
      end
      ST_DISP: begin
        if (cnt_q == CNT_W'(DISP_BYTES - 1)) begin
          done     = 1'b1;
          rec.op   = OP_CALL;
          rec.disp = disp_ext;
        end
      end
      default: done = 1'b1;
    endcase
    if (done) state_d = ST_FIRST;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FIRST;
      wide_q  <= 1'b0;
      len_q   <= '0;
      cnt_q   <= '0;
      disp_q  <= '0;
    end else if (take) begin
      state_q <= state_d;
      if (done) begin
        wide_q <= 1'b0;
        len_q  <= '0;
        cnt_q  <= '0;
        disp_q <= '0;
      end else begin
        wide_q <= wide_q | ((state_q == ST_FIRST) && c_pfx);
        len_q  <= len_now;
        if (state_q == ST_DISP) begin
          cnt_q  <= cnt_q + CNT_W'(1);
          disp_q <= disp_shift;
        end
      end
    end
  end

endmodule

// File: rtl/ibd_out_stage.sv
`timescale 1ns/1ps
// One-entry record holding register on the output stream.
module ibd_out_stage
  import ibd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  rec_t rec_in,
  input  logic out_ready,
  output logic out_valid,
  output rec_t rec_out
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rec_out   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      rec_out   <= rec_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/insn_byte_decoder.sv
`timescale 1ns/1ps
module insn_byte_decoder
  import ibd_pkg::*;
#(
  parameter int DISP_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [2:0]  out_op,
  output logic [2:0]  out_src,
  output logic [2:0]  out_dst,
  output logic        out_wide,
  output logic [63:0] out_disp,
  output logic [3:0]  out_len
);

  logic take, asm_done;
  rec_t asm_rec, held;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  ibd_assembler #(.DISP_BYTES(DISP_BYTES)) i_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .in_byte (in_byte),
    .done    (asm_done),
    .rec     (asm_rec)
  );

  ibd_out_stage i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take && asm_done),
    .rec_in    (asm_rec),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .rec_out   (held)
  );

  assign out_op   = held.op;
  assign out_src  = held.src;
  assign out_dst  = held.dst;
  assign out_wide = held.wide;
  assign out_disp = held.disp;
  assign out_len  = held.len;

endmodule

// File: rtl/ibd_checker.sv
`timescale 1ns/1ps
module ibd_checker #(
  parameter int DISP_BYTES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [2:0]  out_op,
  input logic [2:0]  out_src,
  input logic [2:0]  out_dst,
  input logic        out_wide,
  input logic [63:0] out_disp,
  input logic [3:0]  out_len
);

  AST_HELD_RECORD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_op, out_src, out_dst, out_wide, out_disp, out_len})); // R8
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8
  AST_EMPTY_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R9
  AST_PUSH_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_op == 3'd0 |-> out_len == 4'd1 && out_dst == 3'd0 && !out_wide); // R1
  AST_POP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_op == 3'd1 |-> out_len == 4'd1 && out_src == 3'd0 && !out_wide); // R2
  AST_MOVE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_op == 3'd2 || out_op == 3'd3) |-> out_len == 4'd2 + {3'd0, out_wide}); // R4
  AST_CALL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_op == 3'd4 |-> out_len == 4'(DISP_BYTES + 1) && !out_wide); // R5
  AST_DISP_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_op != 3'd4 |-> out_disp == 64'd0); // R5
  AST_RET_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_op == 3'd5 |-> out_len == 4'd1); // R6
  AST_ILLEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_op == 3'd7 |-> out_src == 3'd0 && out_dst == 3'd0 &&
      out_len >= 4'd1 && out_len <= 4'd3); // R7
  AST_OP_DEFINED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_op != 3'd6); // R7

endmodule

bind insn_byte_decoder ibd_checker #(.DISP_BYTES(DISP_BYTES)) i_ibd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_op    (out_op),
  .out_src   (out_src),
  .out_dst   (out_dst),
  .out_wide  (out_wide),
  .out_disp  (out_disp),
  .out_len   (out_len)
);

// File: tb/test_insn_byte_decoder.sv
`timescale 1ns/1ps
module test_insn_byte_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  out_op, out_src, out_dst;
  logic        out_wide;
  logic [63:0] out_disp;
  logic [3:0]  out_len;

  always #2.5 clk = ~clk;

  insn_byte_decoder i_insn_byte_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_src(out_src), .out_dst(out_dst),
    .out_wide(out_wide), .out_disp(out_disp), .out_len(out_len)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  src;
    logic [2:0]  dst;
    logic        wide;
    logic [63:0] disp;
    logic [3:0]  len;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] stim_q[$];
  int n_chk = 0;
  int n_fail = 0;

  // Behavioural reference model state.
  int          m_st = 0;
  int          m_len = 0;
  int          m_cnt = 0;
  bit          m_wide = 0;
  logic [63:0] m_disp = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic emit(input int op, input int src, input int dst, input logic [63:0] d);
    exp_t e;
    e.op = 3'(op); e.src = 3'(src); e.dst = 3'(dst);
    e.wide = m_wide; e.disp = d; e.len = 4'(m_len);
    exp_q.push_back(e);
    m_st = 0;
  endtask

  task automatic model_byte(input logic [7:0] b);
    case (m_st)
      0: begin
        m_len = 1; m_wide = 0; m_disp = '0;
        if (b == 8'h48) begin m_wide = 1; m_st = 1; end
        else if (b >= 8'h50 && b <= 8'h57) emit(0, int'(b) - 'h50, 0, 64'd0);
        else if (b >= 8'h58 && b <= 8'h5F) emit(1, 0, int'(b) - 'h58, 64'd0);
        else if (b == 8'hC3) emit(5, 0, 0, 64'd0);
        else if (b == 8'hE8) begin m_st = 3; m_cnt = 0; end
        else if (b == 8'h89) m_st = 2;
        else emit(7, 0, 0, 64'd0);
      end
      1: begin
        m_len++;
        if (b == 8'h89) m_st = 2;
        else emit(7, 0, 0, 64'd0);
      end
      2: begin
        m_len++;
        if (b[7:6] == 2'b11) emit(2, int'(b[5:3]), int'(b[2:0]), 64'd0);
        else if (b[7:6] == 2'b00) emit(3, int'(b[5:3]), int'(b[2:0]), 64'd0);
        else emit(7, 0, 0, 64'd0);
      end
      default: begin
        m_len++;
        m_disp = m_disp | (64'(b) << (8 * m_cnt));
        m_cnt++;
        if (m_cnt == 4) begin
          if (m_disp[31]) m_disp[63:32] = '1;
          emit(4, 0, 0, m_disp);
        end
      end
    endcase
  endtask

  function automatic string req_of(input exp_t e);
    if (e.wide) return "R4";
    case (e.op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic put(input logic [7:0] b);
    stim_q.push_back(b);
  endtask

  task automatic build_stim();
    // Mixed program: push, prefixed move, call, prefixed store, pop, return.
    put(8'h53); put(8'h48); put(8'h89); put(8'hD3);
    put(8'hE8); put(8'h00); put(8'h00); put(8'h00); put(8'h00);
    put(8'h48); put(8'h89); put(8'h03); put(8'h5B); put(8'hC3);
    for (int r = 0; r < 8; r++) begin put(8'(8'h50 + r)); put(8'(8'h58 + r)); end
    put(8'h89); put(8'hC1);                     // R3 mode 11 unprefixed
    put(8'h89); put(8'h1A);                     // R3 mode 00 unprefixed
    put(8'h89); put(8'h45);                     // R7 mode 01
    put(8'h48); put(8'h89); put(8'h80);         // R7 mode 10 prefixed
    put(8'h48); put(8'h50);                     // R7 prefix then push
    put(8'h48); put(8'h48); put(8'h53);         // R7 double prefix, then push
    put(8'h00); put(8'hFF);                     // R7 unknown first bytes
    put(8'hE8); put(8'hFC); put(8'hFF); put(8'hFF); put(8'hFF);  // R5 -4
    put(8'hE8); put(8'h78); put(8'h56); put(8'h34); put(8'h12);  // R5 order
    put(8'hE8); put(8'h00); put(8'h00); put(8'h00); put(8'h80);  // R5 sign
    for (int k = 0; k < 1600; k++) begin
      int sel;
      sel = int'($urandom % 10);
      case (sel)
        0: put(8'(8'h50 + ($urandom % 16)));
        1: put(8'h48);
        2, 3: put(8'h89);
        4: put(8'(($urandom % 4) << 6 | ($urandom % 64)));
        5: put(8'hE8);
        6: put(8'hC3);
        default: put(8'($urandom));
      endcase
    end
  endtask

  initial begin : main
    int   idx;
    int   cyc;
    bit   prev_held;
    bit   acc;
    exp_t prev_rec;
    exp_t cur;
    idx = 0; cyc = 0; prev_held = 0; acc = 0; prev_rec = '0;
    build_stim();
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid in reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R9", "in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid after reset", 64'(out_valid), 64'd0);
    forever begin
      @(negedge clk);
      cyc++;
      cur = {out_op, out_src, out_dst, out_wide, out_disp, out_len};
      if (prev_held) begin
        check(out_valid == 1'b1, "R8", "valid dropped while stalled", 64'(out_valid), 64'd1);
        check(cur == prev_rec, "R8", "held record changed", cur[63:0], prev_rec[63:0]);
      end
      // Drive the next cycle's inputs.
      if ((cyc % 200) < 40) out_ready = 1'b0;
      else out_ready = ($urandom % 4) != 0;
      if (acc) in_valid = 1'b0;
      acc = 0;
      if (!in_valid && idx < stim_q.size() && ($urandom % 5) != 0) begin
        in_valid = 1'b1;
        in_byte  = stim_q[idx];
      end
      #1;
      check(in_ready == (!out_valid || out_ready), "R8", "in_ready rule",
            64'(in_ready), 64'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "record with no instruction", cur[63:0], 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({cur.op, cur.src, cur.dst, cur.wide, cur.len} ==
                {e.op, e.src, e.dst, e.wide, e.len}, req_of(e), "record fields",
                64'({cur.op, cur.src, cur.dst, cur.wide, cur.len}),
                64'({e.op, e.src, e.dst, e.wide, e.len}));
          check(cur.disp == e.disp, req_of(e), "displacement", cur.disp, e.disp);
        end
      end
      if (in_valid && in_ready) begin
        model_byte(in_byte);
        idx++;
        acc = 1;
      end
      prev_held = out_valid && !out_ready;
      prev_rec  = cur;
      if (idx == stim_q.size() && exp_q.size() == 0 && !out_valid && !in_valid) break;
      if (cyc > 150000) begin
        check(1'b0, "R10", "watchdog expired", 64'(cyc), 64'd150000);
        break;
      end
    end
    check(idx == stim_q.size(), "R10", "bytes consumed", 64'(idx), 64'(stim_q.size()));
    check(exp_q.size() == 0, "R10", "records missing", 64'(exp_q.size()), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule